// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the address of an instruction fetch into a physical address in one pipeline stage. It picks one of four paths for each request. A fetch address with its lowest bit set marks privileged code, and that fetch skips translation. A physical-mode request passes the address through unchanged. A fixed high window of the virtual space is a superpage that maps straight onto physical space. Every other address is translated through an external TLB.

The block presents the virtual page number and the current address-space number to the TLB. It expects the hit flag, the physical page number and the per-mode execute mask back in the same cycle. Next it checks execute permission for the current mode, rejects physical addresses wider than the implemented width, and applies the rule for uncacheable space: such space may never be fetched from. The result is registered and appears one cycle after the request. It carries a physical address, an uncacheable flag and a 3-bit fault code. The consumer decides how to handle each fault.

Top module: `ifetch_xlat`

## Requirements
- R1: A request with `fetch_va[0]`=1 is a privileged fetch. Its result is `fetch_va` with bits 1:0 cleared and the bits above the 44-bit physical width dropped, with fault code 0 and uncacheable 0, whatever the other inputs are.
- R2: With `phys_mode`=1 (and `fetch_va[0]`=0) the 64-bit physical address is `fetch_va` itself. No validity, superpage or TLB check applies.
- R3: Outside physical mode, a virtual address whose bits 63:42 are neither all zeros nor all ones gives fault code 1 (access violation).
- R4: A valid virtual address with bits 47:41 equal to 7'h7e is a superpage. It is allowed only when `cur_mode`=0 (kernel) and otherwise gives fault code 1. The modes are encoded 0 kernel, 1 executive, 2 supervisor, 3 user.
- R5: A superpage physical address is the VA truncated to 44 bits. If bit 40 of that value is 1, bits 43:40 are forced to ones. Otherwise bits 43:40 are cleared.
- R6: On the TLB path with `tlb_hit`=0, the fault code is 2 (TLB miss).
- R7: On a TLB hit the physical address is `{tlb_ppn, 13'b0}` plus `fetch_va[12:0]` with bits 1:0 cleared.
- R8: On a TLB hit, `tlb_xre[cur_mode]`=0 gives fault code 1.
- R9: When no earlier fault applies and any bit 63:44 of the 64-bit physical address is set, the fault code is 3 (machine check), and `out_pa` holds its low 44 bits.
- R10: When no earlier fault applies and physical address bit 43 is set, `out_uncached`=1, bits 42:35 of `out_pa` are cleared and the fault code is 4 (unimplemented fetch). On faults 1 and 2, `out_pa`=0 and `out_uncached`=0.
- R11: After reset `out_valid`=0 and `out_fault`=0. Each request appears on the outputs exactly one clock later, with `out_valid` high for that one cycle.
- R12: `lkup_vpn` equals `fetch_va[42:13]` and `lkup_asn` equals `cur_asn`, without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A fetch request is present |
| fetch_va | input | 64 | Fetch PC / virtual address |
| phys_mode | input | 1 | Treat the address as physical |
| cur_mode | input | 2 | Current privilege mode |
| cur_asn | input | 8 | Current address-space number |
| lkup_vpn | output | 30 | Page number presented to the TLB |
| lkup_asn | output | 8 | Address-space number presented to the TLB |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_ppn | input | 31 | Physical page number of the hit |
| tlb_xre | input | 4 | Execute enable per mode of the hit |
| out_valid | output | 1 | Result valid |
| out_pa | output | 44 | Physical address |
| out_uncached | output | 1 | Address lies in uncacheable space |
| out_fault | output | 3 | 0 none, 1 access violation, 2 TLB miss, 3 machine check, 4 unimplemented |

## Verification
The hardest cases to reach are the ones where two rules interact on one address. A superpage address with bit 40 set has bit 43 forced on by the sign extension, so it always ends in the uncacheable fault. A privileged fetch with bit 43 set must escape that fault completely. The stimulus builds these addresses on purpose. It also uses a TLB hit whose page number reaches bit 43 and physical-mode addresses above 44 bits, and compares the chosen fault against a priority model in the scoreboard.

// File: rtl/ifetch_xlat_pkg.sv
package ifetch_xlat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ACV   = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_MCHK  = 3'd3,
    FLT_UNIMP = 3'd4
  } fault_e;

  localparam int unsigned  AW        = 64;
  localparam int unsigned  SP_HI     = 47;
  localparam int unsigned  SP_LO     = 41;
  localparam logic [6:0]   SP_TAG    = 7'h7e;
  localparam int unsigned  SX_BIT    = 40;
  localparam int unsigned  UC_LO     = 35;
  localparam logic [1:0]   MODE_KERN = 2'd0;
endpackage

// File: rtl/ifx_va_classify.sv
module ifx_va_classify
  import ifetch_xlat_pkg::*;
#(
  parameter int unsigned VA_W = 43
) (
  input  logic [AW-1:0] va,
  output logic          va_ok,
  output logic          is_super
);
  localparam int unsigned HI_N = AW - VA_W + 1;
  logic [HI_N-1:0] hi_bits;

  always_comb begin
    hi_bits  = va[AW-1:VA_W-1];
    va_ok    = (&hi_bits) | ~(|hi_bits);
    is_super = (va[SP_HI:SP_LO] == SP_TAG);
  end
endmodule

// File: rtl/ifx_path_select.sv
module ifx_path_select
  import ifetch_xlat_pkg::*;
#(
  parameter int unsigned PA_W   = 44,
  parameter int unsigned PG_W   = 13,
  parameter int unsigned MODE_W = 2,
  localparam int unsigned PPN_W = PA_W - PG_W,
  localparam int unsigned NMODE = 1 << MODE_W
) (
  input  logic [AW-1:0]     va,
  input  logic              phys,
  input  logic [MODE_W-1:0] mode,
  input  logic              va_ok,
  input  logic              is_super,
  input  logic              hit,
  input  logic [PPN_W-1:0]  ppn,
  input  logic [NMODE-1:0]  xre,
  output logic [AW-1:0]     raw_pa,
  output fault_e            path_fault,
  output logic              bypass
);
  localparam logic [AW-1:0] IMPL_MASK = {{(AW-PA_W){1'b0}}, {PA_W{1'b1}}};

  logic [AW-1:0] sp_pa;
  logic [AW-1:0] tlb_pa;

  always_comb begin
    sp_pa = va & IMPL_MASK;
    if (sp_pa[SX_BIT]) sp_pa[PA_W-1:SX_BIT] = '1;
    else               sp_pa[PA_W-1:SX_BIT] = '0;
    tlb_pa = {{(AW-PA_W){1'b0}}, ppn, va[PG_W-1:2], 2'b00};
  end

  always_comb begin
    bypass     = va[0];
    path_fault = FLT_NONE;
    raw_pa     = '0;
    if (va[0]) begin
      raw_pa = {va[AW-1:2], 2'b00} & IMPL_MASK;
    end else if (phys) begin
      raw_pa = va;
    end else if (!va_ok) begin
      path_fault = FLT_ACV;
    end else if (is_super) begin
      raw_pa = sp_pa;
      if (mode != MODE_KERN) path_fault = FLT_ACV;
    end else if (!hit) begin
      path_fault = FLT_MISS;
    end else begin
      raw_pa = tlb_pa;
      if (!xre[mode]) path_fault = FLT_ACV;
    end
  end
endmodule

// File: rtl/ifx_phys_check.sv
module ifx_phys_check
  import ifetch_xlat_pkg::*;
#(
  parameter int unsigned PA_W = 44
) (
  input  logic [AW-1:0]   raw_pa,
  input  fault_e          path_fault,
  input  logic            bypass,
  output logic [PA_W-1:0] pa,
  output logic            uncached,
  output fault_e          fault
);
  localparam int unsigned UC_BIT = PA_W - 1;

  logic [PA_W-1:0] clr_mask;

  always_comb begin
    for (int b = 0; b < PA_W; b++) begin
      clr_mask[b] = (b >= UC_LO) && (b < UC_BIT);
    end
  end

  always_comb begin
    pa       = raw_pa[PA_W-1:0];
    uncached = 1'b0;
    fault    = FLT_NONE;
    if (bypass) begin
      fault = FLT_NONE;
    end else if (path_fault != FLT_NONE) begin
      fault = path_fault;
      pa    = '0;
    end else if (|raw_pa[AW-1:PA_W]) begin
      fault = FLT_MCHK;
    end else if (raw_pa[UC_BIT]) begin
      uncached = 1'b1;
      fault    = FLT_UNIMP;
      pa       = raw_pa[PA_W-1:0] & ~clr_mask;
    end
  end
endmodule

// File: rtl/ifetch_xlat.sv
module ifetch_xlat
  import ifetch_xlat_pkg::*;
#(
  parameter int unsigned VA_W   = 43,
  parameter int unsigned PA_W   = 44,
  parameter int unsigned PG_W   = 13,
  parameter int unsigned ASN_W  = 8,
  parameter int unsigned MODE_W = 2,
  localparam int unsigned VPN_W = VA_W - PG_W,
  localparam int unsigned PPN_W = PA_W - PG_W,
  localparam int unsigned NMODE = 1 << MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       fetch_va,
  input  logic              phys_mode,
  input  logic [MODE_W-1:0] cur_mode,
  input  logic [ASN_W-1:0]  cur_asn,
  output logic [VPN_W-1:0]  lkup_vpn,
  output logic [ASN_W-1:0]  lkup_asn,
  input  logic              tlb_hit,
  input  logic [PPN_W-1:0]  tlb_ppn,
  input  logic [NMODE-1:0]  tlb_xre,
  output logic              out_valid,
  output logic [PA_W-1:0]   out_pa,
  output logic              out_uncached,
  output logic [2:0]        out_fault
);
  logic            va_ok;
  logic            is_super;
  logic [AW-1:0]   raw_pa;
  fault_e          path_fault;
  logic            bypass;
  logic [PA_W-1:0] nxt_pa;
  logic            nxt_uc;
  fault_e          nxt_fault;

  logic            valid_q;
  logic [PA_W-1:0] pa_q;
  logic            uc_q;
  logic [2:0]      fault_q;

  assign lkup_vpn = fetch_va[VA_W-1:PG_W];
  assign lkup_asn = cur_asn;

  ifx_va_classify #(.VA_W(VA_W)) u_cls (
    .va       (fetch_va),
    .va_ok    (va_ok),
    .is_super (is_super)
  );

  ifx_path_select #(.PA_W(PA_W), .PG_W(PG_W), .MODE_W(MODE_W)) u_path (
    .va         (fetch_va),
    .phys       (phys_mode),
    .mode       (cur_mode),
    .va_ok      (va_ok),
    .is_super   (is_super),
    .hit        (tlb_hit),
    .ppn        (tlb_ppn),
    .xre        (tlb_xre),
    .raw_pa     (raw_pa),
    .path_fault (path_fault),
    .bypass     (bypass)
  );

  ifx_phys_check #(.PA_W(PA_W)) u_chk (
    .raw_pa     (raw_pa),
    .path_fault (path_fault),
    .bypass     (bypass),
    .pa         (nxt_pa),
    .uncached   (nxt_uc),
    .fault      (nxt_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      uc_q    <= 1'b0;
      fault_q <= FLT_NONE;
    end else if (req_valid) begin
      pa_q    <= nxt_pa;
      uc_q    <= nxt_uc;
      fault_q <= nxt_fault;
    end
  end

  assign out_valid    = valid_q;
  assign out_pa       = pa_q;
  assign out_uncached = uc_q;
  assign out_fault    = fault_q;
endmodule

// File: rtl/ifetch_xlat_chk.sv
module ifetch_xlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [63:0] fetch_va,
  input logic        phys_mode,
  input logic [1:0]  cur_mode,
  input logic        tlb_hit,
  input logic        out_valid,
  input logic [43:0] out_pa,
  input logic        out_uncached,
  input logic [2:0]  out_fault
);
  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  p_idle_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  p_priv_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fetch_va[0]) |=>
      (out_fault == 3'd0 && out_pa[1:0] == 2'b00 && !out_uncached));

  p_super_user_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fetch_va[0] && !phys_mode && (&fetch_va[63:42]) &&
     fetch_va[47:41] == 7'h7e && cur_mode != 2'd0) |=> (out_fault == 3'd1));

  p_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fetch_va[0] && !phys_mode && fetch_va[63:42] == '0 &&
     !tlb_hit) |=> (out_fault == 3'd2));

  p_uc_unimp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_uncached) |-> (out_fault == 3'd4 && out_pa[42:35] == '0));
endmodule

bind ifetch_xlat ifetch_xlat_chk u_ifetch_xlat_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .fetch_va     (fetch_va),
  .phys_mode    (phys_mode),
  .cur_mode     (cur_mode),
  .tlb_hit      (tlb_hit),
  .out_valid    (out_valid),
  .out_pa       (out_pa),
  .out_uncached (out_uncached),
  .out_fault    (out_fault)
);

// File: tb/ifetch_xlat_test.sv
module ifetch_xlat_test;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] fetch_va;
  logic        phys_mode;
  logic [1:0]  cur_mode;
  logic [7:0]  cur_asn;
  logic [29:0] lkup_vpn;
  logic [7:0]  lkup_asn;
  logic        tlb_hit;
  logic [30:0] tlb_ppn;
  logic [3:0]  tlb_xre;
  logic        out_valid;
  logic [43:0] out_pa;
  logic        out_uncached;
  logic [2:0]  out_fault;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct packed {
    logic [43:0] pa;
    logic        uc;
    logic [2:0]  f;
    logic [7:0]  tag;
  } exp_t;
  exp_t sb[$];

  ifetch_xlat uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fetch_va(fetch_va),
    .phys_mode(phys_mode), .cur_mode(cur_mode), .cur_asn(cur_asn),
    .lkup_vpn(lkup_vpn), .lkup_asn(lkup_asn), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre), .out_valid(out_valid),
    .out_pa(out_pa), .out_uncached(out_uncached), .out_fault(out_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic exp_t predict(input logic [63:0] va, input logic ph,
                                   input logic [1:0] md, input logic h,
                                   input logic [30:0] pn, input logic [3:0] xr,
                                   input logic [7:0] tag);
    exp_t e;
    logic [63:0] p;
    e = '0;
    e.tag = tag;
    p = 64'd0;
    if (va[0]) begin
      p = va & 64'h0000_0FFF_FFFF_FFFC;
      e.pa = p[43:0];
      return e;
    end
    if (ph) p = va;
    else if (!(va[63:42] == 22'h0 || va[63:42] == 22'h3FFFFF)) e.f = 3'd1;
    else if (va[47:41] == 7'h7e) begin
      if (md != 2'd0) e.f = 3'd1;
      p = va & 64'h0000_0FFF_FFFF_FFFF;
      if (p[40]) p[43:40] = 4'hF; else p[43:40] = 4'h0;
    end else if (!h) e.f = 3'd2;
    else begin
      p = ({33'd0, pn} << 13) + {51'd0, va[12:2], 2'b00};
      if (!xr[md]) e.f = 3'd1;
    end
    if (e.f != 3'd0) begin
      e.pa = '0;
      return e;
    end
    e.pa = p[43:0];
    if (p[63:44] != 20'd0) e.f = 3'd3;
    else if (p[43]) begin
      e.uc = 1'b1;
      e.f  = 3'd4;
      e.pa[42:35] = 8'd0;
    end
    return e;
  endfunction

  task automatic note(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] va, input logic ph, input logic [1:0] md,
                       input logic [7:0] asn, input logic h, input logic [30:0] pn,
                       input logic [3:0] xr, input logic [7:0] tag);
    @(negedge clk);
    req_valid = 1'b1;
    fetch_va  = va;
    phys_mode = ph;
    cur_mode  = md;
    cur_asn   = asn;
    tlb_hit   = h;
    tlb_ppn   = pn;
    tlb_xre   = xr;
    sb.push_back(predict(va, ph, md, h, pn, xr, tag));
    #1;
    note(lkup_vpn == va[42:13], "R12", "lookup vpn", {34'd0, lkup_vpn}, {34'd0, va[42:13]});
    note(lkup_asn == asn, "R12", "lookup asn", {56'd0, lkup_asn}, {56'd0, asn});
  endtask

  // monitor: pop and compare one expected item per valid result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      string rq;
      if (sb.size() == 0) begin
        note(1'b0, "R11", "unexpected result", {63'd0, out_valid}, 64'd0);
      end else begin
        e  = sb.pop_front();
        rq = $sformatf("R%0d", e.tag);
        note(out_fault == e.f, rq, "fault", {61'd0, out_fault}, {61'd0, e.f});
        note(out_pa == e.pa, rq, "pa", {20'd0, out_pa}, {20'd0, e.pa});
        note(out_uncached == e.uc, rq, "uncached", {63'd0, out_uncached}, {63'd0, e.uc});
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; fetch_va = '0; phys_mode = 1'b0;
    cur_mode = 2'd0; cur_asn = '0; tlb_hit = 1'b0; tlb_ppn = '0; tlb_xre = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    note(out_valid == 1'b0, "R11", "reset valid", {63'd0, out_valid}, 64'd0);
    note(out_fault == 3'd0, "R11", "reset fault", {61'd0, out_fault}, 64'd0);
    rst_n = 1'b1;

    // R1 privileged bypass, including bit 43 and high garbage
    issue(64'h0000_0FFF_0000_1003, 1'b0, 2'd3, 8'h11, 1'b0, '0, 4'h0, 8'd1);
    issue(64'hABCD_E123_4567_89AB, 1'b1, 2'd2, 8'h22, 1'b0, '0, 4'h0, 8'd1);
    // R2 physical mode
    issue(64'h0000_0000_1234_5678, 1'b1, 2'd3, 8'h00, 1'b0, '0, 4'h0, 8'd2);
    // R9 machine check on physical mode address above 44 bits
    issue(64'h0004_0000_0000_1000, 1'b1, 2'd0, 8'h00, 1'b0, '0, 4'h0, 8'd9);
    // R10 uncacheable fetch in physical mode
    issue(64'h0000_0FFF_1234_5678, 1'b1, 2'd0, 8'h00, 1'b0, '0, 4'h0, 8'd10);
    // R3 invalid virtual addresses
    issue(64'h0001_0000_0000_0000, 1'b0, 2'd0, 8'h00, 1'b1, 31'h5, 4'hF, 8'd3);
    issue(64'hFFFF_F000_0000_0400, 1'b0, 2'd0, 8'h00, 1'b1, 31'h5, 4'hF, 8'd3);
    // R4/R5 superpage kernel, bit 40 clear
    issue(64'hFFFF_FC00_0012_3450, 1'b0, 2'd0, 8'h00, 1'b0, '0, 4'h0, 8'd5);
    // R5/R10 superpage bit 40 set ends uncacheable
    issue(64'hFFFF_FD00_0000_2000, 1'b0, 2'd0, 8'h00, 1'b0, '0, 4'h0, 8'd5);
    // R4 superpage from user and supervisor
    issue(64'hFFFF_FC00_0012_3450, 1'b0, 2'd3, 8'h00, 1'b1, 31'h7, 4'hF, 8'd4);
    issue(64'hFFFF_FC00_0000_0010, 1'b0, 2'd2, 8'h00, 1'b1, 31'h7, 4'hF, 8'd4);
    // R6 TLB miss
    issue(64'h0000_0000_0004_6006, 1'b0, 2'd0, 8'h33, 1'b0, 31'h7, 4'hF, 8'd6);
    issue(64'hFFFF_FFFF_FFFF_E000, 1'b0, 2'd3, 8'h44, 1'b0, '0, 4'hF, 8'd6);
    // R7 TLB hit address formation
    issue(64'h0000_0000_0004_6006, 1'b0, 2'd0, 8'h33, 1'b1, 31'h0012_3456, 4'h1, 8'd7);
    issue(64'h0000_0123_4567_9FFE, 1'b0, 2'd1, 8'h55, 1'b1, 31'h0000_0ABC, 4'h2, 8'd7);
    // R8 permission per mode
    issue(64'h0000_0000_0000_2004, 1'b0, 2'd3, 8'h00, 1'b1, 31'h10, 4'h7, 8'd8);
    issue(64'h0000_0000_0000_2004, 1'b0, 2'd3, 8'h00, 1'b1, 31'h10, 4'h8, 8'd8);
    issue(64'h0000_0000_0000_2004, 1'b0, 2'd2, 8'h00, 1'b1, 31'h10, 4'hB, 8'd8);
    // R10 TLB hit landing in uncacheable space
    issue(64'h0000_0000_0000_0104, 1'b0, 2'd0, 8'h00, 1'b1, 31'h7FFF_FFFF, 4'h1, 8'd10);

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R11 idle stream gives no result and nothing left pending
    note(out_valid == 1'b0, "R11", "idle valid", {63'd0, out_valid}, 64'd0);
    note(sb.size() == 0, "R11", "pending results", 64'(sb.size()), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule